// File: doc/BRIEF.md
# Hardware Cursor Overlay Mixer

This block is one stage of a video scanout pipeline. Each pixel cycle it receives the beam coordinates, the background colour already resolved by the main palette, and the cursor placement. It then produces the final 24-bit RGB pixel. A 64 by 64 cursor image is stored on chip as 2-bit codes, packed eight to a 16-bit word. A code of zero lets the background show through. The other three codes pick one of three cursor colours held in a small palette.

Software loads the cursor image and the cursor colours through a simple write port. These writes may arrive at any time, including during active video, and they never hold up the pixel stream. The cursor placement arrives as one packed word: the vertical start is in the low 12 bits and the horizontal start is in the 12 bits above it. A separate disable input hides the cursor completely. The result is registered, so it appears one clock after its inputs, together with a delayed copy of the pixel-valid flag.

Top module: `cursorMixer`

## Requirements
- R1: After reset, outValid and outColor are 0 and all three cursor palette entries read as black (0x000000).
- R2: outValid equals pixValid delayed by one clock. When outValid is 0, outColor is 0.
- R3: A pixel outside the cursor window is output as bgColor, one clock after it is presented.
- R4: The cursor X start is cursorPos[23:12] and the cursor Y start is cursorPos[11:0]. The window covers X start to X start+63 inclusive and Y start to Y start+63 inclusive.
- R5: Inside the window, let dx = beamX - X start and dy = beamY - Y start. The pattern word used is dy*8 + dx/8. The pixel code is taken from bits 2*(dx mod 8)+1 down to 2*(dx mod 8) of that word.
- R6: Code 0 outputs bgColor. Codes 1, 2 and 3 output cursor palette entries 0, 1 and 2. Each entry is 24-bit RGB: red in bits 23:16, green in 15:8, blue in 7:0.
- R7: While cursorOff is 1, every valid pixel is output as bgColor.
- R8: The window test is unsigned and does not wrap. With X start near 4095, small beamX values stay outside the window. The same holds for Y.
- R9: A write happens when wrEn is 1. With wrSel=0, pattern word wrAddr is loaded with wrData[15:0]. With wrSel=1, palette entry wrAddr (0 to 2) is loaded with wrData. Palette index 3 is ignored. A write affects pixels from the next clock onward, and a write in the same cycle as a pixel does not disturb that pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixValid | input | 1 | Current inputs describe an active pixel |
| beamX | input | 12 | Horizontal beam coordinate |
| beamY | input | 12 | Vertical beam coordinate |
| bgColor | input | 24 | Palette-resolved background RGB |
| cursorPos | input | 24 | Packed cursor start: X in 23:12, Y in 11:0 |
| cursorOff | input | 1 | 1 hides the cursor |
| wrEn | input | 1 | Write strobe for pattern or palette |
| wrSel | input | 1 | 0 selects pattern memory, 1 selects cursor palette |
| wrAddr | input | 9 | Pattern word index or palette index |
| wrData | input | 24 | Write data (pattern uses 15:0) |
| outValid | output | 1 | Delayed pixel-valid flag |
| outColor | output | 24 | Final RGB pixel |

## Verification
The assertions check several properties on every cycle. They check that the valid flag lags its input by one clock, and that idle cycles output black. They also check that a disabled cursor, or a pixel left of or above the cursor start, passes the background through unchanged. Some behaviour depends on stored contents, so only the bench scenarios can show it. These are the pattern word and lane indexing, the choice of palette entry by code, the exact window edges at offsets 63 and 64, the no-wrap case near coordinate 4095, the dropped palette index 3, and a write landing in the same cycle as a pixel.

// File: rtl/cursorMixPkg.sv
package cursorMixPkg;
  localparam int CoordW     = 12;
  localparam int CurDim     = 64;
  localparam int PixPerWord = 8;
  localparam int CodeW      = 2;
  localparam int WordW      = PixPerWord * CodeW;
  localparam int ColorW     = 24;
  localparam int PalEntries = 3;
  localparam int DimW       = $clog2(CurDim);
  localparam int LaneW      = $clog2(PixPerWord);
  localparam int WordsRow   = CurDim / PixPerWord;
  localparam int PatDepth   = CurDim * WordsRow;
  localparam int PatAddrW   = $clog2(PatDepth);
  localparam int PalIdxW    = $clog2(PalEntries + 1);

  typedef struct packed {
    logic                pixValid;
    logic                hit;
    logic [PatAddrW-1:0] wordIdx;
    logic [LaneW-1:0]    lane;
    logic                patWe;
    logic                palWe;
    logic [PalIdxW-1:0]  palIdx;
  } ctrlStrobes_t;
endpackage

// File: rtl/cursorCtrl.sv
module cursorCtrl
  import cursorMixPkg::*;
(
  input  logic                  pixValid,
  input  logic [CoordW-1:0]     beamX,
  input  logic [CoordW-1:0]     beamY,
  input  logic [2*CoordW-1:0]   cursorPos,
  input  logic                  cursorOff,
  input  logic                  wrEn,
  input  logic                  wrSel,
  input  logic [PatAddrW-1:0]   wrAddr,
  output ctrlStrobes_t          strobes
);
  logic [CoordW-1:0] curX, curY;
  logic [CoordW:0]   dxFull, dyFull;
  logic              inX, inY;

  assign curX = cursorPos[2*CoordW-1:CoordW];
  assign curY = cursorPos[CoordW-1:0];

  // one extra bit keeps the borrow, so a beam left of the start never wraps in
  assign dxFull = {1'b0, beamX} - {1'b0, curX};
  assign dyFull = {1'b0, beamY} - {1'b0, curY};
  assign inX    = !dxFull[CoordW] && (dxFull[CoordW-1:DimW] == '0);
  assign inY    = !dyFull[CoordW] && (dyFull[CoordW-1:DimW] == '0);

  always_comb begin
    strobes          = '0;
    strobes.pixValid = pixValid;
    strobes.hit      = inX && inY && !cursorOff;
    strobes.wordIdx  = {dyFull[DimW-1:0], dxFull[DimW-1:LaneW]};
    strobes.lane     = dxFull[LaneW-1:0];
    strobes.patWe    = wrEn && !wrSel;
    strobes.palWe    = wrEn && wrSel && (wrAddr < PatAddrW'(PalEntries));
    strobes.palIdx   = wrAddr[PalIdxW-1:0];
  end
endmodule

// File: rtl/cursorPath.sv
module cursorPath
  import cursorMixPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [PatAddrW-1:0] wrAddr,
  input  logic [ColorW-1:0]   wrData,
  input  logic [ColorW-1:0]   bgColor,
  output logic                outValid,
  output logic [ColorW-1:0]   outColor
);
  logic [WordW-1:0]  patMem [PatDepth];
  logic [ColorW-1:0] palReg [PalEntries];
  logic [WordW-1:0]  patWord;
  logic [CodeW-1:0]  code;
  logic [ColorW-1:0] mixColor;

  // pattern store: separate write port, read port is combinational
  always_ff @(posedge clk) begin
    if (strobes.patWe) patMem[wrAddr] <= wrData[WordW-1:0];
  end

  for (genvar g = 0; g < PalEntries; g++) begin : genPal
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        palReg[g] <= '0;
      else if (strobes.palWe && (strobes.palIdx == PalIdxW'(g)))
        palReg[g] <= wrData;
    end
  end

  assign patWord = patMem[strobes.wordIdx];
  assign code    = patWord[strobes.lane*CodeW +: CodeW];

  always_comb begin
    mixColor = bgColor;
    if (strobes.hit) begin
      for (int i = 0; i < PalEntries; i++) begin
        if (code == CodeW'(i + 1)) mixColor = palReg[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outColor <= '0;
    end else begin
      outValid <= strobes.pixValid;
      outColor <= strobes.pixValid ? mixColor : '0;
    end
  end
endmodule

// File: rtl/cursorMixer.sv
module cursorMixer
  import cursorMixPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                pixValid,
  input  logic [11:0]         beamX,
  input  logic [11:0]         beamY,
  input  logic [23:0]         bgColor,
  input  logic [23:0]         cursorPos,
  input  logic                cursorOff,
  input  logic                wrEn,
  input  logic                wrSel,
  input  logic [8:0]          wrAddr,
  input  logic [23:0]         wrData,
  output logic                outValid,
  output logic [23:0]         outColor
);
  ctrlStrobes_t strobes;

  cursorCtrl uCtrl (
    .pixValid (pixValid),
    .beamX    (beamX),
    .beamY    (beamY),
    .cursorPos(cursorPos),
    .cursorOff(cursorOff),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrAddr   (wrAddr),
    .strobes  (strobes)
  );

  cursorPath uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .bgColor (bgColor),
    .outValid(outValid),
    .outColor(outColor)
  );
endmodule

// File: rtl/cursorMixChk.sv
module cursorMixChk
  import cursorMixPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        pixValid,
  input logic [11:0] beamX,
  input logic [11:0] beamY,
  input logic [23:0] bgColor,
  input logic [23:0] cursorPos,
  input logic        cursorOff,
  input logic        outValid,
  input logic [23:0] outColor
);
  logic [CoordW:0] startX, startY;
  assign startX = {1'b0, cursorPos[2*CoordW-1:CoordW]};
  assign startY = {1'b0, cursorPos[CoordW-1:0]};

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> outValid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !outValid);

  // R2
  idle_black_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outColor == '0));

  // R7
  off_bg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && cursorOff) |=> (outColor == $past(bgColor)));

  // R3
  left_bg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && ({1'b0, beamX} < startX)) |=> (outColor == $past(bgColor)));

  // R8
  above_bg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && ({1'b0, beamY} < startY)) |=> (outColor == $past(bgColor)));
endmodule

bind cursorMixer cursorMixChk uChk (.*);

// File: tb/sim_cursorMixer.sv
module sim_cursorMixer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pixValid = 1'b0;
  logic [11:0] beamX = '0, beamY = '0;
  logic [23:0] bgColor = '0, cursorPos = '0;
  logic        cursorOff = 1'b0;
  logic        wrEn = 1'b0, wrSel = 1'b0;
  logic [8:0]  wrAddr = '0;
  logic [23:0] wrData = '0;
  logic        outValid;
  logic [23:0] outColor;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [15:0] mPat [512];
  logic [23:0] mPal [3];

  always #10 clk = ~clk;

  cursorMixer u0 (.*);

  function automatic logic [23:0] expColor(int x, int y, logic [23:0] bg);
    int cx, cy, dx, dy;
    logic [15:0] w;
    logic [1:0] cd;
    cx = int'(cursorPos[23:12]);
    cy = int'(cursorPos[11:0]);
    if (cursorOff || x < cx || x >= cx + 64 || y < cy || y >= cy + 64) return bg;
    dx = x - cx;
    dy = y - cy;
    w  = mPat[dy * 8 + dx / 8];
    cd = w[2 * (dx % 8) +: 2];
    if (cd == 2'd0) return bg;
    return mPal[cd - 1];
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrPat(int a, logic [15:0] d);
    @(negedge clk);
    wrEn = 1; wrSel = 0; wrAddr = 9'(a); wrData = {8'h00, d};
    @(negedge clk);
    wrEn = 0;
    mPat[a] = d;
  endtask

  task automatic wrPal(int a, logic [23:0] d);
    @(negedge clk);
    wrEn = 1; wrSel = 1; wrAddr = 9'(a); wrData = d;
    @(negedge clk);
    wrEn = 0;
    if (a < 3) mPal[a] = d;
  endtask

  task automatic pix(string req, int x, int y, logic [23:0] bg);
    logic [23:0] e;
    @(negedge clk);
    pixValid = 1; beamX = 12'(x); beamY = 12'(y); bgColor = bg;
    e = expColor(x, y, bg);
    @(negedge clk);
    pixValid = 0;
    check(req, {23'd0, outValid}, 24'd1);
    check(req, outColor, e);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      finishRun();
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    for (int i = 0; i < 3; i++) mPal[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {23'd0, outValid}, 24'd0);
    check("R1", outColor, 24'd0);
    rstN = 1;
    @(negedge clk);
    // R1 palette black after reset: codes 1,2,3 in lanes 0..2
    wrPat(0, 16'b00_00_00_00_00_11_10_01);
    cursorPos = 24'h000000;
    pix("R1", 0, 0, 24'habcdef);
    pix("R1", 1, 0, 24'habcdef);
    pix("R1", 2, 0, 24'habcdef);

    // fill the whole pattern and palettes
    for (int a = 0; a < 512; a++) wrPat(a, 16'($urandom));
    wrPal(0, 24'hff0000);
    wrPal(1, 24'h00ff00);
    wrPal(2, 24'h0000ff);

    // R6 directed codes
    wrPat(0, 16'b00_00_00_00_11_10_01_00);
    pix("R6", 0, 0, 24'h123456);
    pix("R6", 1, 0, 24'h123456);
    pix("R6", 2, 0, 24'h123456);
    pix("R6", 3, 0, 24'h123456);

    // R9 palette index 3 ignored
    wrPal(3, 24'h777777);
    pix("R9", 3, 0, 24'h123456);
    pix("R9", 1, 0, 24'h123456);

    // R4 / R5 placement and edges
    cursorPos = {12'd100, 12'd50};
    wrPat(63 * 8 + 7, 16'hc000);
    wrPat(5 * 8 + 2, 16'h0030);
    pix("R4", 163, 113, 24'h0a0b0c);
    pix("R4", 164, 113, 24'h0a0b0c);
    pix("R4", 163, 114, 24'h0a0b0c);
    pix("R3", 99, 60, 24'h0a0b0c);
    pix("R3", 120, 49, 24'h0a0b0c);
    pix("R5", 118, 55, 24'h0a0b0c);
    pix("R4", 100, 50, 24'h0a0b0c);

    // R8 no wrap near the top of the coordinate range
    cursorPos = {12'd4090, 12'd4090};
    pix("R8", 2, 4092, 24'h445566);
    pix("R8", 4092, 3, 24'h445566);
    pix("R8", 4095, 4095, 24'h445566);
    pix("R8", 4090, 4090, 24'h445566);

    // R7 disable
    cursorPos = {12'd10, 12'd10};
    wrPat(0, 16'hffff);
    cursorOff = 1;
    pix("R7", 10, 10, 24'h0f0f0f);
    pix("R7", 12, 11, 24'h0f0f0f);
    cursorOff = 0;
    pix("R7", 10, 10, 24'h0f0f0f);

    // R2 idle pixel gives black and low valid
    @(negedge clk);
    pixValid = 0; beamX = 12'd10; beamY = 12'd10; bgColor = 24'hffffff;
    @(negedge clk);
    check("R2", {23'd0, outValid}, 24'd0);
    check("R2", outColor, 24'd0);

    // R9 write in the same cycle as a pixel
    wrPat(1, 16'h0000);
    @(negedge clk);
    pixValid = 1; beamX = 12'd10; beamY = 12'd10; bgColor = 24'h202020;
    wrEn = 1; wrSel = 0; wrAddr = 9'd1; wrData = 24'h005555;
    @(negedge clk);
    pixValid = 0; wrEn = 0;
    check("R9", outColor, mPal[2]);
    mPat[1] = 16'h5555;
    pix("R9", 18, 10, 24'h202020);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int cx, cy, x, y;
      if (it % 40 == 0) begin
        cursorPos = {12'($urandom % 200), 12'($urandom % 200)};
        if (it % 80 == 0) wrPal(int'($urandom % 3), 24'($urandom));
      end
      cx = int'(cursorPos[23:12]);
      cy = int'(cursorPos[11:0]);
      x = cx + int'($urandom % 80) - 8;
      y = cy + int'($urandom % 80) - 8;
      if (x < 0) x = 0;
      if (y < 0) y = 0;
      pix("R5", x, y, 24'($urandom));
    end

    done = 1;
    finishRun();
  end
endmodule